// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block carries out the protected load of a data or stack segment register. A request gives a 16-bit selector and a target (data or stack). The block first splits the selector into three parts: a requested privilege, a table select bit, and a 13-bit index. It checks the index against the limit of the chosen table. If the index is in range, it forms the descriptor address as the table base plus eight times the index. It then fetches the 8-byte descriptor as two 32-bit reads over a request/valid port.

The effective privilege is the numerically larger (weaker) of the current privilege level and the requested privilege. The load passes only when the descriptor is present and the effective privilege is at most the descriptor's privilege level. On a pass, the selector and the whole descriptor go into the target's visible and shadow registers. On a failure, the registers keep their values and the block reports a fault whose type depends on the target.

The controller is a state machine with six states:
- `S_IDLE` waits for `load_req` and latches the request, then moves to `S_DECODE`.
- `S_DECODE` goes to `S_REPORT` with a fault when the index is over the limit, and to `S_FETCH_LO` otherwise.
- `S_FETCH_LO` moves to `S_FETCH_HI` when the low word arrives.
- `S_FETCH_HI` moves to `S_EVAL` when the high word arrives.
- `S_EVAL` judges privilege and presence, writes the registers on a pass, and moves to `S_REPORT`.
- `S_REPORT` pulses `done` or `fault` for one cycle and returns to `S_IDLE`.

The current privilege level is held in a register. The surrounding pipeline writes it through `cpl_wr`/`cpl_wdata`.

Top module: `seg_load_checker`

## Requirements
- R1: After reset, the current privilege level, all four segment registers (both selectors and both descriptors), `busy`, `done`, `fault`, `fault_code` and `mem_req` are all zero. The privilege register takes `cpl_wdata` one cycle after `cpl_wr`.
- R2: Selector bits 1:0 are the requested privilege. Bit 2 picks the table: 0 for global, 1 for local. Bits 15:3 are the index.
- R3: The low descriptor word is read from address base + index*8 and the high word from base + index*8 + 4, in that order. `mem_addr` stays stable while `mem_req` waits for `mem_rvalid`.
- R4: An index greater than the selected table's limit input faults without raising `mem_req` at any point during that load.
- R5: The effective privilege is max(current privilege, requested privilege). The load passes only when descriptor bit 47 (present) is 1 and the effective privilege is at most descriptor bits 46:45.
- R6: A failed data-segment load reports `fault_code` 2'b01. A failed stack-segment load reports 2'b10. `fault_code` is 2'b00 whenever `fault` is low.
- R7: On a failure, none of the four segment registers changes.
- R8: On a pass, the target's selector and 64-bit descriptor ({high word, low word}) already hold the new values in the cycle where `done` is high. The other target's registers do not change.
- R9: `done` and `fault` are single-cycle pulses, never both high. `busy` is high from the cycle after the request until the cycle before that pulse.
- R10: `mem_req` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_wr | input | 1 | Write strobe for the current privilege level |
| cpl_wdata | input | 2 | New current privilege level |
| load_req | input | 1 | Start a segment load (accepted when idle) |
| load_stack | input | 1 | Target select: 0 data segment, 1 stack segment |
| load_sel | input | 16 | Selector to load |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 13 | Highest valid global index |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 13 | Highest valid local index |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_rvalid | input | 1 | Read data valid; completes the pending request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load succeeded (one-cycle pulse) |
| fault | output | 1 | Load failed (one-cycle pulse) |
| fault_code | output | 2 | 01 general protection, 10 stack fault |
| cpl | output | 2 | Current privilege level |
| ds_sel | output | 16 | Data segment visible selector |
| ds_desc | output | 64 | Data segment shadow descriptor |
| ss_sel | output | 16 | Stack segment visible selector |
| ss_desc | output | 64 | Stack segment shadow descriptor |

## Verification
The assertions assume that `mem_rvalid` is raised only while `mem_req` is high and lasts one cycle per word. They also assume that `load_req` and `cpl_wr` arrive only while the block is idle. The bench's memory model answers only a pending request, with a latency that varies from zero to two cycles and a one-cycle valid pulse. The bench issues requests and privilege writes only after the previous load has reported. The sweep covers every privilege pair, both tables, both targets, and indices on both sides of each limit.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;
    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int PL_W   = 2;
    localparam int WORD_W = 32;
    localparam int DESC_W = 2 * WORD_W;
    localparam int NSEG   = 2;
    localparam int PRES_BIT = 47;
    localparam int DPL_LSB  = 45;

    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_FETCH_LO, S_FETCH_HI, S_EVAL, S_REPORT
    } ld_state_t;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_GPROT = 2'b01,
        FC_STACK = 2'b10
    } fault_code_t;

    function automatic fault_code_t code_for(input logic is_stack);
        return is_stack ? FC_STACK : FC_GPROT;
    endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode #(
    parameter int AW = 32
) (
    input  logic [seg_load_pkg::SEL_W-1:0] sel,
    input  logic [AW-1:0]                  gbase,
    input  logic [seg_load_pkg::IDX_W-1:0] glimit,
    input  logic [AW-1:0]                  lbase,
    input  logic [seg_load_pkg::IDX_W-1:0] llimit,
    output logic [seg_load_pkg::PL_W-1:0]  rpl,
    output logic [AW-1:0]                  lo_addr,
    output logic                           over_limit
);
    import seg_load_pkg::*;
    localparam int OFS_SH = 3;

    logic             use_local;
    logic [IDX_W-1:0] index;
    logic [AW-1:0]    offset;

    always_comb begin
        rpl        = sel[PL_W-1:0];
        use_local  = sel[PL_W];
        index      = sel[SEL_W-1:OFS_SH];
        offset     = AW'({index, {OFS_SH{1'b0}}});
        lo_addr    = (use_local ? lbase : gbase) + offset;
        over_limit = index > (use_local ? llimit : glimit);
    end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check (
    input  logic [seg_load_pkg::PL_W-1:0]   cur_pl,
    input  logic [seg_load_pkg::PL_W-1:0]   req_pl,
    input  logic [seg_load_pkg::DESC_W-1:0] desc,
    output logic                            allow
);
    import seg_load_pkg::*;
    logic [PL_W-1:0] eff_pl;
    logic [PL_W-1:0] dpl;

    always_comb begin
        eff_pl = (req_pl > cur_pl) ? req_pl : cur_pl;
        dpl    = desc[DPL_LSB +: PL_W];
        allow  = desc[PRES_BIT] && (eff_pl <= dpl);
    end
endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_en,
    input  logic                                        wr_idx,
    input  logic [seg_load_pkg::SEL_W-1:0]              wr_sel,
    input  logic [seg_load_pkg::DESC_W-1:0]             wr_desc,
    output logic [seg_load_pkg::NSEG*seg_load_pkg::SEL_W-1:0]  sel_flat,
    output logic [seg_load_pkg::NSEG*seg_load_pkg::DESC_W-1:0] desc_flat
);
    import seg_load_pkg::*;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SEL_W-1:0]  sel_q;
        logic [DESC_W-1:0] desc_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_q  <= '0;
                desc_q <= '0;
            end else if (wr_en && (int'(wr_idx) == g)) begin
                sel_q  <= wr_sel;
                desc_q <= wr_desc;
            end
        end
        assign sel_flat[g*SEL_W +: SEL_W]     = sel_q;
        assign desc_flat[g*DESC_W +: DESC_W]  = desc_q;
    end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker #(
    parameter int AW = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpl_wr,
    input  logic [1:0]  cpl_wdata,
    input  logic        load_req,
    input  logic        load_stack,
    input  logic [15:0] load_sel,
    input  logic [AW-1:0] gdt_base,
    input  logic [12:0] gdt_limit,
    input  logic [AW-1:0] ldt_base,
    input  logic [12:0] ldt_limit,
    output logic        mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        fault,
    output logic [1:0]  fault_code,
    output logic [1:0]  cpl,
    output logic [15:0] ds_sel,
    output logic [63:0] ds_desc,
    output logic [15:0] ss_sel,
    output logic [63:0] ss_desc
);
    import seg_load_pkg::*;
    localparam int HI_OFS = WORD_W / 8;

    ld_state_t         state_q, state_d;
    logic [SEL_W-1:0]  sel_q;
    logic              stack_q;
    logic [WORD_W-1:0] lo_q, hi_q;
    logic [AW-1:0]     addr_q;
    logic              ok_q;
    logic [PL_W-1:0]   cpl_q;

    logic [PL_W-1:0]   rpl;
    logic [AW-1:0]     lo_addr;
    logic              over_limit;
    logic              allow;
    logic [DESC_W-1:0] desc_full;
    logic              wr_en;
    logic [NSEG*SEL_W-1:0]  sel_flat;
    logic [NSEG*DESC_W-1:0] desc_flat;

    assign desc_full = {hi_q, lo_q};

    seg_sel_decode #(.AW(AW)) u_dec (
        .sel(sel_q), .gbase(gdt_base), .glimit(gdt_limit),
        .lbase(ldt_base), .llimit(ldt_limit),
        .rpl(rpl), .lo_addr(lo_addr), .over_limit(over_limit)
    );

    seg_priv_check u_chk (
        .cur_pl(cpl_q), .req_pl(rpl), .desc(desc_full), .allow(allow)
    );

    seg_shadow_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(stack_q),
        .wr_sel(sel_q), .wr_desc(desc_full),
        .sel_flat(sel_flat), .desc_flat(desc_flat)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (load_req) state_d = S_DECODE;
            S_DECODE:   state_d = over_limit ? S_REPORT : S_FETCH_LO;
            S_FETCH_LO: if (mem_rvalid) state_d = S_FETCH_HI;
            S_FETCH_HI: if (mem_rvalid) state_d = S_EVAL;
            S_EVAL:     state_d = S_REPORT;
            S_REPORT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_addr   = addr_q;
        busy       = 1'b0;
        done       = 1'b0;
        fault      = 1'b0;
        fault_code = FC_NONE;
        wr_en      = 1'b0;
        unique case (state_q)
            S_IDLE:     ;
            S_DECODE:   busy = 1'b1;
            S_FETCH_LO: begin busy = 1'b1; mem_req = 1'b1; end
            S_FETCH_HI: begin busy = 1'b1; mem_req = 1'b1; end
            S_EVAL:     begin busy = 1'b1; wr_en = allow; end
            S_REPORT: begin
                done  = ok_q;
                fault = !ok_q;
                if (!ok_q) fault_code = code_for(stack_q);
            end
            default:    ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            stack_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            addr_q  <= '0;
            ok_q    <= 1'b0;
            cpl_q   <= '0;
        end else begin
            if (cpl_wr) cpl_q <= cpl_wdata;
            unique case (state_q)
                S_IDLE: if (load_req) begin
                    sel_q   <= load_sel;
                    stack_q <= load_stack;
                end
                S_DECODE: begin
                    addr_q <= lo_addr;
                    ok_q   <= 1'b0;
                end
                S_FETCH_LO: if (mem_rvalid) begin
                    lo_q   <= mem_rdata;
                    addr_q <= addr_q + AW'(HI_OFS);
                end
                S_FETCH_HI: if (mem_rvalid) hi_q <= mem_rdata;
                S_EVAL:     ok_q <= allow;
                S_REPORT:   ;
                default:    ;
            endcase
        end
    end

    assign cpl     = cpl_q;
    assign ds_sel  = sel_flat[0 +: SEL_W];
    assign ss_sel  = sel_flat[SEL_W +: SEL_W];
    assign ds_desc = desc_flat[0 +: DESC_W];
    assign ss_desc = desc_flat[DESC_W +: DESC_W];
endmodule

// File: rtl/seg_load_checker_sva.sv
module seg_load_checker_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        busy,
    input logic        done,
    input logic        fault,
    input logic [1:0]  fault_code,
    input logic [15:0] ds_sel,
    input logic [63:0] ds_desc,
    input logic [15:0] ss_sel,
    input logic [63:0] ss_desc
);
    a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r6_code_when_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code == 2'b01 || fault_code == 2'b10));

    a_r6_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_code == 2'b00));

    a_r7_regs_kept: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(ds_sel) && $stable(ds_desc) && $stable(ss_sel) && $stable(ss_desc)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> !(done || fault));

    a_r9_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> !busy);

    a_r10_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
endmodule

bind seg_load_checker seg_load_checker_sva u_sva (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .fault(fault),
    .fault_code(fault_code), .ds_sel(ds_sel), .ds_desc(ds_desc),
    .ss_sel(ss_sel), .ss_desc(ss_desc)
);

// File: tb/seg_load_checker_tb.sv
module seg_load_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpl_wr = 1'b0;
    logic [1:0]  cpl_wdata = '0;
    logic        load_req = 1'b0;
    logic        load_stack = 1'b0;
    logic [15:0] load_sel = '0;
    logic [31:0] gdt_base = 32'h0000_1000;
    logic [12:0] gdt_limit = 13'd6;
    logic [31:0] ldt_base = 32'h0000_2000;
    logic [12:0] ldt_limit = 13'd5;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_code, cpl;
    logic [15:0] ds_sel, ss_sel;
    logic [63:0] ds_desc, ss_desc;

    int n_tests = 0;
    int n_fail  = 0;
    int lat     = 0;
    int req_cycles;
    int rd_count;
    logic [31:0] rd_addr [2];

    always #4 clk = ~clk;

    seg_load_checker u_dut (
        .clk(clk), .rst_n(rst_n), .cpl_wr(cpl_wr), .cpl_wdata(cpl_wdata),
        .load_req(load_req), .load_stack(load_stack), .load_sel(load_sel),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .cpl(cpl), .ds_sel(ds_sel), .ds_desc(ds_desc),
        .ss_sel(ss_sel), .ss_desc(ss_desc)
    );

    function automatic logic [63:0] make_desc(input int idx, input int tbl);
        logic [1:0] dpl;
        logic       pres;
        dpl  = 2'((idx + tbl) % 4);
        pres = ((idx + 2 * tbl) % 5) != 3;
        return {16'hC0DE ^ 16'(idx), pres, dpl, 13'h1234 ^ 13'(tbl),
                16'(idx * 16'h0111 + tbl), 16'hA5A5 ^ 16'(idx)};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        int tbl;
        int idx;
        logic [63:0] d;
        tbl = (a >= 32'h2000) ? 1 : 0;
        idx = int'((a - (tbl != 0 ? 32'h2000 : 32'h1000)) >> 3);
        d   = make_desc(idx, tbl);
        return a[2] ? d[63:32] : d[31:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: answers pending requests only
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                if (cnt >= lat) begin
                    if (rd_count < 2) rd_addr[rd_count] = mem_addr;
                    rd_count++;
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_word(mem_addr);
                end else cnt++;
            end
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    logic [15:0] e_ds_sel = '0, e_ss_sel = '0;
    logic [63:0] e_ds_desc = '0, e_ss_desc = '0;

    task automatic do_load(input int cp, input int rp, input int tbl, input int idx, input int stk);
        logic [15:0] sel;
        logic [63:0] d;
        logic [31:0] base;
        int eff;
        int lim;
        bit over, pass;
        int waitc;
        logic [1:0] exp_code;
        sel  = {13'(idx), 1'(tbl), 2'(rp)};
        d    = make_desc(idx, tbl);
        base = (tbl != 0) ? ldt_base : gdt_base;
        lim  = (tbl != 0) ? int'(ldt_limit) : int'(gdt_limit);
        over = idx > lim;
        eff  = (cp > rp) ? cp : rp;
        pass = !over && d[47] && (eff <= int'(d[46:45]));
        exp_code = pass ? 2'b00 : (stk != 0 ? 2'b10 : 2'b01);

        cpl_wr = 1'b1; cpl_wdata = 2'(cp);
        @(negedge clk);
        cpl_wr = 1'b0;
        check(cpl == 2'(cp), "R1 cpl write", 64'(cpl), 64'(cp));

        rd_count = 0; req_cycles = 0;
        load_req = 1'b1; load_sel = sel; load_stack = 1'(stk);
        @(negedge clk);
        load_req = 1'b0;
        waitc = 0;
        while (!(done || fault) && waitc < 60) begin
            if (!busy) check(1'b0, "R9 busy during load", 64'(busy), 64'(1));
            if (mem_req) req_cycles++;
            @(negedge clk);
            waitc++;
        end
        check(done == pass && fault == !pass, "R5 pass/fail", {62'b0, done, fault}, {62'b0, pass, !pass});
        check(fault_code == exp_code, "R6 fault code", 64'(fault_code), 64'(exp_code));
        check(!busy, "R9 busy low at end", 64'(busy), 64'(0));
        if (over) begin
            check(req_cycles == 0 && rd_count == 0, "R4 no read on limit fault", 64'(req_cycles), 64'(0));
        end else begin
            check(rd_count == 2, "R3 two reads", 64'(rd_count), 64'(2));
            check(rd_addr[0] == base + 32'(idx * 8), "R3 low addr", 64'(rd_addr[0]), 64'(base + 32'(idx * 8)));
            check(rd_addr[1] == base + 32'(idx * 8 + 4), "R3 high addr", 64'(rd_addr[1]), 64'(base + 32'(idx * 8 + 4)));
        end
        if (pass) begin
            if (stk != 0) begin e_ss_sel = sel; e_ss_desc = d; end
            else          begin e_ds_sel = sel; e_ds_desc = d; end
        end
        // R2/R7/R8: registers match model (updated target only on pass)
        check(ds_sel == e_ds_sel, pass ? "R8 ds selector" : "R7 ds selector", 64'(ds_sel), 64'(e_ds_sel));
        check(ds_desc == e_ds_desc, pass ? "R8 ds descriptor" : "R7 ds descriptor", ds_desc, e_ds_desc);
        check(ss_sel == e_ss_sel, pass ? "R8 ss selector" : "R7 ss selector", 64'(ss_sel), 64'(e_ss_sel));
        check(ss_desc == e_ss_desc, pass ? "R8 ss descriptor" : "R7 ss descriptor", ss_desc, e_ss_desc);
        @(negedge clk);
        check(!done && !fault, "R9 single pulse", {62'b0, done, fault}, 64'(0));
        check(!mem_req || busy, "R10 req only when busy", 64'(mem_req), 64'(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cpl == 2'd0, "R1 cpl reset", 64'(cpl), 64'(0));
        check(!busy && !done && !fault && !mem_req && fault_code == 2'b00,
              "R1 control reset", {59'b0, busy, done, fault, mem_req, |fault_code}, 64'(0));
        check(ds_sel == 0 && ss_sel == 0 && ds_desc == 0 && ss_desc == 0,
              "R1 segment reset", ds_desc | ss_desc, 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        for (int cp = 0; cp < 4; cp++)
            for (int rp = 0; rp < 4; rp++)
                for (int tbl = 0; tbl < 2; tbl++)
                    for (int stk = 0; stk < 2; stk++)
                        for (int idx = 0; idx < 8; idx++) begin
                            lat = (idx + rp) % 3;
                            do_load(cp, rp, tbl, idx, stk);
                        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule